// File: doc/BRIEF.md
# Floating-Point Coprocessor Bus Sequencer

This block is the bus-facing control path of a floating-point slave coprocessor. The master first announces an instruction with an 8-bit identifier. It then sends a 16-bit operation word followed by 16-bit operand words. The sequencer decodes the operation word and works out how many operand bytes it must collect. Operands that are encoded as register-direct are fetched from a local file of eight 32-bit floating-point registers instead of being taken from the bus. Double-precision values occupy an even/odd register pair.

Once every operand is present, the sequencer hands them to a stand-in execution unit. That unit returns a 64-bit result and a 16-bit status word. A timer then runs for the operation's cycle count and ends with a one-clock low pulse on the completion strobe. The master reads the status word and then reads the result words one by one. A floating-point result with a register destination goes back into the register file and is never placed on the bus.

The stand-in execution unit is deliberately trivial: the result is the 64-bit sum of the two collected operands, and the status word reports operand equality for a compare. This makes every data path observable at the ports.

Top module: `fpc_bus_seq`

## Requirements
- R1: Only identifier 0x3E (format A) and 0xBE (format B) arm the block for an operation word. Any other identifier returns it to idle without flagging an error, and an operation word that follows is rejected as a protocol error.
- R2: The operation word is taken byte-swapped: bus bits 7:0 become operation bits 15:8.
- R3: Operand words fill the operand little-endian. Each word lands at a byte offset equal to the number of bytes already received for that operand, and each word counts as 2 bytes. The first operand is filled before the second.
- R4: Format B: the opcode is bits 5:2, and bit 0 set means 4-byte single precision, clear means 8-byte double. Even opcodes take two operands and odd opcodes take one. Every opcode except 2 (compare) returns a result of the precision length.
- R5: Format A: the opcode is bits 5:3, bit 2 selects single precision and bits 1:0 are an integer size code s with integer length s+1. Opcode 0 reads an integer and returns a float. Opcode 1 reads 4 bytes and returns nothing. Opcode 2 reads 8 bytes and returns a float. Opcode 3 reads 4 bytes and returns a float. Opcodes 4, 5 and 7 read a float and return an integer. Opcode 6 reads nothing and returns 4 bytes.
- R6: The first operand comes from register bits 13:11 when bits 15:14 are zero, except for format A opcodes 0 and 1. The second operand comes from register bits 8:6 when bits 10:9 are zero. A double operand is register n (low half) with register n XOR 1 (high half).
- R7: A floating-point result (format B, or format A opcodes 0 to 3) with bits 10:9 zero is written to register bits 8:6, as a pair when double. No result words are then offered on the bus.
- R8: A status read in the status state returns the status word. It moves the block to idle when no result bytes are pending and to the result state otherwise.
- R9: Result words stream out little-endian, 2 bytes per read. The read that covers the last result byte returns the block to idle.
- R10: The operation starts one clock after its last operand is present. Exactly C clocks after the start, the completion strobe goes low for one clock. C is 13 for format A opcode 6. For format B opcodes 0 and 4 it is 70 with any memory mode and 74 otherwise, and for format B compare it is 45 or 49 on the same rule. All other operations use 20 or 24. Memory mode means bits 15:14 are nonzero, or, in format B only, bits 10:9 are nonzero.
- R11: An operation word in the wrong state, an extra operand word, or a read in the wrong state sets a sticky error flag. A bad read returns zero data, and the state is left unchanged.
- R12: The stand-in unit returns operand1 + operand2 (64-bit, with a missing operand taken as zero). Its status bit 0 is set only for a format B compare with equal operands, and all other status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_wr | input | 1 | Identifier write strobe |
| id_data | input | 8 | Identifier byte |
| op_wr | input | 1 | Operation/operand word write strobe |
| op_wdata | input | 16 | Operation or operand word |
| st_rd | input | 1 | Status read strobe |
| res_rd | input | 1 | Result word read strobe |
| rd_data | output | 16 | Read data, registered, valid the clock after a read strobe |
| done_n | output | 1 | Completion strobe, active-low one-clock pulse |
| proto_err | output | 1 | Sticky protocol error flag |

## Verification
The bench uses the default configuration: eight registers of 32 bits and an 8-bit cycle counter. With these values the entire opcode space can be swept. That means all 16 format B opcodes in both precisions, and all 8 format A opcodes across the four integer size codes and both precisions, with operands on the bus and lengths, sums and strobe delays computed arithmetically. Register pairs are loaded through write-back and read back through register-sourced moves, which exercises the n XOR 1 pairing. The protocol-error paths are each checked after a fresh reset so that the sticky flag isolates a single cause.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam logic [7:0] ID_FMT_A = 8'h3E;
  localparam logic [7:0] ID_FMT_B = 8'hBE;
  localparam int CYC_W = 8;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPW  = 3'd1,
    S_OPD  = 3'd2,
    S_STAT = 3'd4,
    S_RES  = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic [3:0]       len0;
    logic [3:0]       len1;
    logic [3:0]       lenr;
    logic             src0_reg;
    logic             src1_reg;
    logic             wb;
    logic             is_cmp;
    logic [2:0]       idx0;
    logic [2:0]       idx1;
    logic [CYC_W-1:0] cycles;
  } op_dec_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  logic        fmt_b,
  input  logic [15:0] opw,
  output op_dec_t     dec
);
  logic [3:0] flen;
  logic [3:0] ilen;
  logic       mem_a, mem_b;

  always_comb begin
    dec    = '0;
    flen   = 4'd8;
    ilen   = {2'b00, opw[1:0]} + 4'd1;
    mem_a  = |opw[15:14];
    mem_b  = |{opw[15:14], opw[10:9]};
    dec.idx0 = opw[13:11];
    dec.idx1 = opw[8:6];
    if (fmt_b) begin
      flen     = opw[0] ? 4'd4 : 4'd8;
      dec.len0 = flen;
      dec.len1 = opw[2] ? 4'd0 : flen;
      dec.lenr = (opw[5:2] == 4'd2) ? 4'd0 : flen;
      dec.is_cmp = (opw[5:2] == 4'd2);
      case (opw[5:2])
        4'd0, 4'd4: dec.cycles = mem_b ? CYC_W'(70) : CYC_W'(74);
        4'd2:       dec.cycles = mem_b ? CYC_W'(45) : CYC_W'(49);
        default:    dec.cycles = mem_b ? CYC_W'(20) : CYC_W'(24);
      endcase
      dec.src0_reg = (opw[15:14] == 2'b00);
      dec.src1_reg = (dec.len1 != 4'd0) && (opw[10:9] == 2'b00);
      dec.wb       = (dec.lenr != 4'd0) && (opw[10:9] == 2'b00);
    end else begin
      flen = opw[2] ? 4'd4 : 4'd8;
      case (opw[5:3])
        3'd0: begin dec.len0 = ilen;  dec.lenr = flen; end
        3'd1: begin dec.len0 = 4'd4; end
        3'd2: begin dec.len0 = 4'd8;  dec.lenr = flen; end
        3'd3: begin dec.len0 = 4'd4;  dec.lenr = flen; end
        3'd6: begin dec.lenr = 4'd4; end
        default: begin dec.len0 = flen; dec.lenr = ilen; end
      endcase
      dec.cycles   = (opw[5:3] == 3'd6) ? CYC_W'(13) : (mem_a ? CYC_W'(20) : CYC_W'(24));
      dec.src0_reg = (dec.len0 != 4'd0) && (opw[15:14] == 2'b00) && (opw[5:3] > 3'd1);
      dec.wb       = (dec.lenr != 4'd0) && (opw[10:9] == 2'b00) && (opw[5:3] < 3'd4);
    end
  end
endmodule

// File: rtl/fpc_regfile.sv
module fpc_regfile #(
  parameter int NREG  = 8,
  parameter int REG_W = 32
) (
  input  logic                   clk,
  input  logic [$clog2(NREG)-1:0] rd_idx0,
  input  logic [$clog2(NREG)-1:0] rd_idx1,
  output logic [2*REG_W-1:0]     rd_pair0,
  output logic [2*REG_W-1:0]     rd_pair1,
  input  logic                   we,
  input  logic                   we_dbl,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [2*REG_W-1:0]     wr_data
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int HALF   = NREG / 2;

  // even and odd banks, so a pair n / n^1 is one entry in each bank
  logic [REG_W-1:0] bank_e [HALF];
  logic [REG_W-1:0] bank_o [HALF];

  function automatic logic [2*REG_W-1:0] pair_of(input logic [IDX_W-1:0] n,
                                                 input logic [REG_W-1:0] ev,
                                                 input logic [REG_W-1:0] od);
    return n[0] ? {ev, od} : {od, ev};
  endfunction

  assign rd_pair0 = pair_of(rd_idx0, bank_e[rd_idx0[IDX_W-1:1]], bank_o[rd_idx0[IDX_W-1:1]]);
  assign rd_pair1 = pair_of(rd_idx1, bank_e[rd_idx1[IDX_W-1:1]], bank_o[rd_idx1[IDX_W-1:1]]);

  logic             we_e, we_o;
  logic [REG_W-1:0] wd_e, wd_o;
  always_comb begin
    we_e = we && (!wr_idx[0] || we_dbl);
    we_o = we && ( wr_idx[0] || we_dbl);
    wd_e = wr_idx[0] ? wr_data[2*REG_W-1:REG_W] : wr_data[REG_W-1:0];
    wd_o = wr_idx[0] ? wr_data[REG_W-1:0] : wr_data[2*REG_W-1:REG_W];
  end

  always_ff @(posedge clk) begin
    if (we_e) bank_e[wr_idx[IDX_W-1:1]] <= wd_e;
    if (we_o) bank_o[wr_idx[IDX_W-1:1]] <= wd_o;
  end
endmodule

// File: rtl/fpc_exec_stub.sv
module fpc_exec_stub #(
  parameter int OPW = 64
) (
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  input  logic           is_cmp,
  output logic [OPW-1:0] result,
  output logic [15:0]    status
);
  always_comb begin
    result = opa + opb;
    status = {15'b0, is_cmp && (opa == opb)};
  end
endmodule

// File: rtl/fpc_bus_seq.sv
module fpc_bus_seq
  import fpc_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int REG_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        id_wr,
  input  logic [7:0]  id_data,
  input  logic        op_wr,
  input  logic [15:0] op_wdata,
  input  logic        st_rd,
  input  logic        res_rd,
  output logic [15:0] rd_data,
  output logic        done_n,
  output logic        proto_err
);
  localparam int OPW   = 2 * REG_W;
  localparam int IDX_W = $clog2(NREG);

  seq_state_e       state;
  logic             fmt_b;
  op_dec_t          dec_in, dec_q;
  logic [OPW-1:0]   opa, opb, res_q;
  logic [3:0]       cnt_a, cnt_b, res_len, res_cnt;
  logic [15:0]      stat_q;
  logic [CYC_W-1:0] cyc_cnt;
  logic [OPW-1:0]   pair0, pair1, ex_res;
  logic [15:0]      ex_stat;
  logic [15:0]      opw_swapped;
  logic             all_in, fire;

  assign opw_swapped = {op_wdata[7:0], op_wdata[15:8]};

  fpc_decode u_dec (
    .fmt_b (fmt_b),
    .opw   (opw_swapped),
    .dec   (dec_in)
  );

  fpc_exec_stub #(.OPW(OPW)) u_exec (
    .opa    (opa),
    .opb    (opb),
    .is_cmp (dec_q.is_cmp),
    .result (ex_res),
    .status (ex_stat)
  );

  assign all_in = (cnt_a >= dec_q.len0) && (cnt_b >= dec_q.len1);
  assign fire   = (state == S_OPD) && all_in && !id_wr && !op_wr && !st_rd && !res_rd;

  fpc_regfile #(.NREG(NREG), .REG_W(REG_W)) u_rf (
    .clk      (clk),
    .rd_idx0  (IDX_W'(dec_in.idx0)),
    .rd_idx1  (IDX_W'(dec_in.idx1)),
    .rd_pair0 (pair0),
    .rd_pair1 (pair1),
    .we       (fire && dec_q.wb),
    .we_dbl   (dec_q.lenr == 4'd8),
    .wr_idx   (IDX_W'(dec_q.idx1)),
    .wr_data  (ex_res)
  );

  function automatic logic [OPW-1:0] mask_len(input logic [OPW-1:0] v, input logic [3:0] len);
    return (len == 4'd4) ? {{(OPW-REG_W){1'b0}}, v[REG_W-1:0]} : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      fmt_b     <= 1'b0;
      dec_q     <= '0;
      opa       <= '0;
      opb       <= '0;
      cnt_a     <= '0;
      cnt_b     <= '0;
      res_q     <= '0;
      res_len   <= '0;
      res_cnt   <= '0;
      stat_q    <= '0;
      rd_data   <= '0;
      proto_err <= 1'b0;
    end else if (id_wr) begin
      fmt_b <= (id_data == ID_FMT_B);
      state <= ((id_data == ID_FMT_A) || (id_data == ID_FMT_B)) ? S_OPW : S_IDLE;
    end else if (op_wr) begin
      if (state == S_OPW) begin
        dec_q <= dec_in;
        opa   <= dec_in.src0_reg ? mask_len(pair0, dec_in.len0) : '0;
        cnt_a <= dec_in.src0_reg ? dec_in.len0 : 4'd0;
        opb   <= dec_in.src1_reg ? mask_len(pair1, dec_in.len1) : '0;
        cnt_b <= dec_in.src1_reg ? dec_in.len1 : 4'd0;
        state <= S_OPD;
      end else if (state == S_OPD && cnt_a < dec_q.len0) begin
        opa   <= opa | (OPW'(op_wdata) << {cnt_a, 3'b000});
        cnt_a <= cnt_a + 4'd2;
      end else if (state == S_OPD && cnt_b < dec_q.len1) begin
        opb   <= opb | (OPW'(op_wdata) << {cnt_b, 3'b000});
        cnt_b <= cnt_b + 4'd2;
      end else begin
        proto_err <= 1'b1;
      end
    end else if (st_rd) begin
      if (state == S_STAT) begin
        rd_data <= stat_q;
        state   <= (res_len == 4'd0) ? S_IDLE : S_RES;
      end else begin
        rd_data   <= '0;
        proto_err <= 1'b1;
      end
    end else if (res_rd) begin
      if (state == S_RES) begin
        rd_data <= 16'(res_q >> {res_cnt, 3'b000});
        res_cnt <= res_cnt + 4'd2;
        if (res_cnt + 4'd2 >= res_len) state <= S_IDLE;
      end else begin
        rd_data   <= '0;
        proto_err <= 1'b1;
      end
    end else if (fire) begin
      res_q   <= ex_res;
      stat_q  <= ex_stat;
      res_len <= dec_q.wb ? 4'd0 : dec_q.lenr;
      res_cnt <= 4'd0;
      state   <= S_STAT;
    end
  end

  // completion timer
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt <= '0;
      done_n  <= 1'b1;
    end else begin
      done_n <= 1'b1;
      if (fire) begin
        cyc_cnt <= dec_q.cycles;
      end else if (cyc_cnt != '0) begin
        cyc_cnt <= cyc_cnt - 1'b1;
        if (cyc_cnt == CYC_W'(1)) done_n <= 1'b0;
      end
    end
  end

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    !done_n |=> done_n);
  assert_bad_id_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (id_wr && id_data != ID_FMT_A && id_data != ID_FMT_B) |=> state == S_IDLE);
  assert_status_leave_R8: assert property (@(posedge clk) disable iff (rst)
    (!id_wr && !op_wr && st_rd && state == S_STAT) |=> (state == S_IDLE || state == S_RES));
  assert_res_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_RES) |-> (res_cnt < res_len));
  assert_wb_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_STAT && dec_q.wb) |-> (res_len == 4'd0));
endmodule

// File: tb/fpc_bus_seq_test.sv
module fpc_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        id_wr = 1'b0;
  logic [7:0]  id_data = '0;
  logic        op_wr = 1'b0;
  logic [15:0] op_wdata = '0;
  logic        st_rd = 1'b0;
  logic        res_rd = 1'b0;
  logic [15:0] rd_data;
  logic        done_n;
  logic        proto_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpc_bus_seq uut (
    .clk(clk), .rst(rst), .id_wr(id_wr), .id_data(id_data),
    .op_wr(op_wr), .op_wdata(op_wdata), .st_rd(st_rd), .res_rd(res_rd),
    .rd_data(rd_data), .done_n(done_n), .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask
  task automatic put_id(input logic [7:0] b);
    @(negedge clk); id_wr = 1'b1; id_data = b;
    @(negedge clk); id_wr = 1'b0;
  endtask
  task automatic put_word(input logic [15:0] w);
    @(negedge clk); op_wr = 1'b1; op_wdata = w;
    @(negedge clk); op_wr = 1'b0;
  endtask
  task automatic put_opw(input logic [15:0] opw);
    put_word({opw[7:0], opw[15:8]});
  endtask
  task automatic get_st(output logic [15:0] v);
    @(negedge clk); st_rd = 1'b1;
    @(negedge clk); st_rd = 1'b0; v = rd_data;
  endtask
  task automatic get_res(output logic [15:0] v);
    @(negedge clk); res_rd = 1'b1;
    @(negedge clk); res_rd = 1'b0; v = rd_data;
  endtask
  // clocks from last write until the strobe is seen low
  task automatic wait_done(output int k);
    k = 0;
    while (done_n === 1'b1 && k < 300) begin
      @(negedge clk); k++;
    end
  endtask

  // send n bytes as ceil(n/2) words; return the assembled value
  task automatic send_operand(input int nbytes, input logic [15:0] seed, output logic [63:0] val);
    val = '0;
    for (int i = 0; i < (nbytes + 1) / 2; i++) begin
      logic [15:0] w;
      w = seed ^ (16'h1357 * 16'(i + 1));
      put_word(w);
      val = val | (64'(w) << (16 * i));
    end
  endtask

  task automatic run_op(input string tag, input logic fmt_b, input logic [15:0] opw,
                        input int l0, input int l1, input int lr, input int cyc,
                        input logic [15:0] sa, input logic [15:0] sb, input bit is_cmp);
    logic [63:0] a, b, r;
    logic [15:0] v;
    int k;
    put_id(fmt_b ? 8'hBE : 8'h3E);
    put_opw(opw);
    send_operand(l0, sa, a);
    send_operand(l1, sb, b);
    wait_done(k);
    check({tag, " R10 strobe delay"}, 64'(k), 64'(cyc + 1));
    get_st(v);
    check({tag, " R12 R8 status"}, 64'(v), 64'(is_cmp && (a == b)));
    r = a + b;
    for (int i = 0; i < (lr + 1) / 2; i++) begin
      get_res(v);
      check({tag, " R3 R9 R12 result word"}, 64'(v), 64'(r[16*i +: 16]));
    end
    check({tag, " R11 no error"}, 64'(proto_err), 64'(0));
  endtask

  logic [31:0] regv [8];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [63:0] sum;
    int k;
    do_reset();
    check("R10 reset strobe", 64'(done_n), 64'(1));
    check("R11 reset error flag", 64'(proto_err), 64'(0));
    check("R8 reset read data", 64'(rd_data), 64'(0));

    // format B sweep, operands from the bus (memory modes)
    for (int opc = 0; opc < 16; opc++) begin
      for (int sp = 0; sp < 2; sp++) begin
        int fl, l1, lr, cyc;
        logic [15:0] opw;
        fl  = sp ? 4 : 8;
        l1  = (opc % 2 == 1) ? 0 : fl;
        lr  = (opc == 2) ? 0 : fl;
        cyc = (opc == 0 || opc == 4) ? 70 : (opc == 2) ? 45 : 20;
        opw = 16'h4200 | 16'(opc << 2) | 16'(sp);
        run_op("R4 fmtB", 1'b1, opw, fl, l1, lr, cyc,
               16'hA5C3 ^ 16'(opc), sp ? (16'hA5C3 ^ 16'(opc)) : 16'h0F1E, opc == 2);
      end
    end

    // format A sweep over opcode, size code and precision
    for (int opc = 0; opc < 8; opc++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int sp = 0; sp < 2; sp++) begin
          int fl, il, l0, lr;
          logic [15:0] opw;
          fl = sp ? 4 : 8;
          il = sz + 1;
          case (opc)
            0: begin l0 = il; lr = fl; end
            1: begin l0 = 4;  lr = 0;  end
            2: begin l0 = 8;  lr = fl; end
            3: begin l0 = 4;  lr = fl; end
            6: begin l0 = 0;  lr = 4;  end
            default: begin l0 = fl; lr = il; end
          endcase
          opw = 16'h4200 | 16'(opc << 3) | 16'(sp << 2) | 16'(sz);
          run_op("R5 R2 fmtA", 1'b0, opw, l0, 0, lr, (opc == 6) ? 13 : 20,
                 16'h3C5A ^ 16'(opc * 8 + sz), 16'h0, 1'b0);
        end
      end
    end

    // load registers by single-precision move with register destination
    for (int r = 0; r < 8; r++) begin
      logic [63:0] a;
      regv[r] = 32'h1234_5678 ^ (32'h1111_1111 * 32'(r));
      put_id(8'hBE);
      put_opw(16'h4000 | 16'(r << 6) | 16'h0005);
      put_word(regv[r][15:0]);
      put_word(regv[r][31:16]);
      a = 64'(regv[r]);
      wait_done(k);
      check("R7 write-back move delay R10", 64'(k), 64'(21));
      get_st(v);
      check("R7 write-back status", 64'(v), 64'(0));
    end

    // single move register 3 to bus
    put_id(8'hBE);
    put_opw(16'h0000 | 16'(3 << 11) | 16'h0200 | 16'h0005);
    wait_done(k);
    check("R6 single reg source delay", 64'(k), 64'(21));
    get_st(v);
    get_res(v); check("R6 single reg low", 64'(v), 64'(regv[3][15:0]));
    get_res(v); check("R6 single reg high", 64'(v), 64'(regv[3][31:16]));

    // double add, both register sourced, written back to pair 5/4
    sum = {regv[3], regv[2]} + {regv[4], regv[5]};
    put_id(8'hBE);
    put_opw(16'(2 << 11) | 16'(5 << 6));
    wait_done(k);
    check("R6 R10 all-register add delay", 64'(k), 64'(75));
    get_st(v);
    check("R8 status after write-back", 64'(v), 64'(0));
    // move double register 5 to bus: low = reg5, high = reg4
    put_id(8'hBE);
    put_opw(16'(5 << 11) | 16'h0200 | 16'h0004);
    wait_done(k);
    get_st(v);
    for (int i = 0; i < 4; i++) begin
      get_res(v);
      check("R6 R7 pair read-back", 64'(v), 64'(sum[16*i +: 16]));
    end
    check("R9 clean stream", 64'(proto_err), 64'(0));

    // after a write-back status read, the block is idle
    put_id(8'hBE);
    put_opw(16'(1 << 11) | 16'(6 << 6) | 16'h0005);
    wait_done(k);
    get_st(v);
    get_res(v);
    check("R8 idle after write-back status data", 64'(v), 64'(0));
    check("R8 idle after write-back status err", 64'(proto_err), 64'(1));

    // status read in idle
    do_reset();
    get_st(v);
    check("R11 idle status read data", 64'(v), 64'(0));
    check("R11 idle status read err", 64'(proto_err), 64'(1));

    // unknown identifier
    do_reset();
    put_id(8'h55);
    check("R1 bad id not an error", 64'(proto_err), 64'(0));
    put_opw(16'h4205);
    check("R1 op word after bad id rejected", 64'(proto_err), 64'(1));

    // extra result read after the last word
    do_reset();
    put_id(8'h3E);
    put_opw(16'h4230);
    wait_done(k);
    check("R10 store status delay", 64'(k), 64'(14));
    get_st(v); get_res(v); get_res(v);
    check("R9 no error before extra read", 64'(proto_err), 64'(0));
    get_res(v);
    check("R9 R11 extra read data", 64'(v), 64'(0));
    check("R9 R11 extra read err", 64'(proto_err), 64'(1));

    // extra operand word while status is pending
    do_reset();
    put_id(8'hBE);
    put_opw(16'h4205);
    put_word(16'h1111); put_word(16'h2222);
    wait_done(k);
    put_word(16'h3333);
    check("R11 extra operand word", 64'(proto_err), 64'(1));
    get_st(v);
    get_res(v); check("R11 state kept, result low", 64'(v), 64'(16'h1111));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule